// File: doc/BRIEF.md
# Amplitude-Path Table Predistorter with Interpolation

This block corrects the amplitude path of a polar transmitter before the samples reach the power stage. Each incoming amplitude code addresses two lookup tables: one holds the drive amplitude that produces the wanted output, and one holds the phase shift the stage adds at that amplitude. The stored values are used as they are. No inverse of the measured curve is formed. Between table points the block interpolates along a straight line, so a small table covers the whole code range.

The upper bits of the amplitude code choose a table segment and the lower bits give the position inside it. A resolution control, chosen per power level, sets how many of those position bits take part in the interpolation. The interpolated phase correction is added to the incoming phase sample with wraparound. The amplitude and phase results leave the block together after a fixed pipeline delay.

Tables are loaded through a single write port. That port only works while the datapath is disabled, so a running burst never sees a table change partway through.

Top module: `amdpd_core`

## Requirements
- R1: During and just after a synchronous active-high reset, `out_valid` is 0 and `amp_out` and `ph_out` are 0.
- R2: A sample accepted at a rising clock edge appears on `amp_out`/`ph_out` with `out_valid` high exactly 3 rising edges later. Amplitude and phase results of one sample appear in the same cycle, and samples leave in arrival order.
- R3: A sample is accepted only when `in_valid` and `en` are both 1. Otherwise no output is produced for it.
- R4: With the default 12-bit amplitude code, index i is bits [11:6] and fraction f is bits [5:0]. The amplitude table holds unsigned entries A. The output is A[i] + floor((A[i+1] - A[i]) * f / 64), using signed arithmetic.
- R5: When i is 63 (the last entry), A[63] stands in for A[i+1], so the output is A[63] for any fraction.
- R6: `res_bits` = r keeps only the upper r bits of the 6-bit fraction and zeroes the rest before interpolation. r = 0 gives the plain table entry. Any r of 6 or more uses the full fraction.
- R7: The phase table holds 12-bit two's-complement entries P. They are interpolated by the same rule as R4, R5 and R6. `ph_out` = (`ph_in` + interpolated P) mod 4096.
- R8: A write with `tbl_we` = 1 stores `tbl_data` at `tbl_addr`. It goes to the amplitude table when `tbl_sel` = 0 and to the phase table when `tbl_sel` = 1. It takes effect only when `en` = 0. While `en` = 1 the write is ignored.
- R9: Between valid results, `amp_out` and `ph_out` keep their last values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Datapath enable; also blocks table writes when high |
| in_valid | input | 1 | Sample strobe |
| amp_in | input | 12 | Amplitude code |
| ph_in | input | 12 | Phase sample |
| res_bits | input | 3 | Number of fraction bits used (power-level resolution) |
| tbl_we | input | 1 | Table write strobe |
| tbl_sel | input | 1 | 0 selects the amplitude table, 1 the phase table |
| tbl_addr | input | 6 | Table entry |
| tbl_data | input | 12 | Entry value |
| out_valid | output | 1 | Result strobe |
| amp_out | output | 12 | Predistorted amplitude |
| ph_out | output | 12 | Corrected phase |

## Verification
The test starts with codes whose fraction is zero, which separates table addressing from the interpolation arithmetic. Mid-segment codes follow on both a rising and a falling table segment; these expose rounding direction and sign handling in the slope. A sweep of codes and phases across every resolution setting, including values above the fraction width, shows that the fraction masking and its clamping work. Further cases cover the last table entry, phase sums that wrap past full scale, a write attempted while the datapath is enabled, and strobes given while it is disabled; these show that neighbour saturation, modular addition and both gating rules behave as required.

// File: rtl/amdpd_pkg.sv
package amdpd_pkg;
  typedef enum logic {
    TBL_AMP = 1'b0,
    TBL_PH  = 1'b1
  } tbl_sel_e;
endpackage

// File: rtl/amdpd_tbl.sv
// Table with one write port and two registered read ports.
// Implemented as two identical simple dual-port copies (block RAM style).
module amdpd_tbl #(
  parameter int AW = 6,
  parameter int DW = 12
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr_lo,
  input  logic [AW-1:0] raddr_hi,
  output logic [DW-1:0] rdata_lo,
  output logic [DW-1:0] rdata_hi
);
  localparam int DEPTH = 1 << AW;

  logic [AW-1:0] ra [2];
  logic [DW-1:0] rd [2];

  assign ra[0]    = raddr_lo;
  assign ra[1]    = raddr_hi;
  assign rdata_lo = rd[0];
  assign rdata_hi = rd[1];

  for (genvar p = 0; p < 2; p++) begin : g_copy
    logic [DW-1:0] mem [DEPTH];
    always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
      rd[p] <= mem[ra[p]];
    end
  end
endmodule

// File: rtl/amdpd_interp.sv
// Two-stage straight-line interpolation with an added offset (modular).
module amdpd_interp #(
  parameter int DW     = 12,
  parameter int FW     = 6,
  parameter bit SIGNED = 1'b0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ld_a,
  input  logic          ld_b,
  input  logic [DW-1:0] lo,
  input  logic [DW-1:0] hi,
  input  logic [FW-1:0] frac,
  input  logic [DW-1:0] offs,
  output logic [DW-1:0] y
);
  localparam int EW = DW + 1;
  localparam int PW = EW + FW + 1;

  logic signed [EW-1:0] lo_x, hi_x, diff;
  logic signed [PW-1:0] prod_c, prod_q;
  logic signed [PW-1:0] step;
  logic        [DW-1:0] base_q, offs_q;
  logic        [PW-1:0] sum;

  if (SIGNED) begin : g_sx
    assign lo_x = {lo[DW-1], lo};
    assign hi_x = {hi[DW-1], hi};
  end else begin : g_zx
    assign lo_x = {1'b0, lo};
    assign hi_x = {1'b0, hi};
  end

  assign diff   = hi_x - lo_x;
  assign prod_c = PW'(diff) * $signed({{(PW-FW){1'b0}}, frac});
  assign step   = prod_q >>> FW;
  assign sum    = PW'(base_q) + PW'(offs_q) + PW'(step);

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q <= '0;
      offs_q <= '0;
      prod_q <= '0;
      y      <= '0;
    end else begin
      if (ld_a) begin
        base_q <= lo;
        offs_q <= offs;
        prod_q <= prod_c;
      end
      if (ld_b) y <= sum[DW-1:0];
    end
  end
endmodule

// File: rtl/amdpd_core.sv
module amdpd_core #(
  parameter int AMP_W = 12,
  parameter int PH_W  = 12,
  parameter int IDX_W = 6,
  parameter int RES_W = $clog2(AMP_W - IDX_W + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             in_valid,
  input  logic [AMP_W-1:0] amp_in,
  input  logic [PH_W-1:0]  ph_in,
  input  logic [RES_W-1:0] res_bits,
  input  logic             tbl_we,
  input  logic             tbl_sel,
  input  logic [IDX_W-1:0] tbl_addr,
  input  logic [AMP_W-1:0] tbl_data,
  output logic             out_valid,
  output logic [AMP_W-1:0] amp_out,
  output logic [PH_W-1:0]  ph_out
);
  import amdpd_pkg::*;

  localparam int FW      = AMP_W - IDX_W;
  localparam int LAST    = (1 << IDX_W) - 1;
  localparam int CW      = (PH_W < AMP_W) ? PH_W : AMP_W;

  // input decode
  logic             take;
  logic [IDX_W-1:0] idx, idx_hi;
  logic [FW-1:0]    frac_raw, frac_msk, keep;
  int               r_eff;

  assign take     = in_valid & en;
  assign idx      = amp_in[AMP_W-1:FW];
  assign frac_raw = amp_in[FW-1:0];
  assign idx_hi   = (idx == IDX_W'(LAST)) ? idx : idx + 1'b1;

  always_comb begin
    r_eff = (int'(res_bits) > FW) ? FW : int'(res_bits);
    for (int b = 0; b < FW; b++) keep[b] = (b >= FW - r_eff);
    frac_msk = frac_raw & keep;
  end

  // table writes, gated by the enable
  logic wr_ok, amp_we, ph_we;
  assign wr_ok  = tbl_we & ~en;
  assign amp_we = wr_ok & (tbl_sel == TBL_AMP);
  assign ph_we  = wr_ok & (tbl_sel == TBL_PH);

  logic [AMP_W-1:0] a_lo, a_hi;
  logic [PH_W-1:0]  p_lo, p_hi, p_wdata;

  assign p_wdata = PH_W'(tbl_data[CW-1:0]);

  amdpd_tbl #(.AW(IDX_W), .DW(AMP_W)) u_amp_tbl (
    .clk(clk), .we(amp_we), .waddr(tbl_addr), .wdata(tbl_data),
    .raddr_lo(idx), .raddr_hi(idx_hi), .rdata_lo(a_lo), .rdata_hi(a_hi)
  );

  amdpd_tbl #(.AW(IDX_W), .DW(PH_W)) u_ph_tbl (
    .clk(clk), .we(ph_we), .waddr(tbl_addr), .wdata(p_wdata),
    .raddr_lo(idx), .raddr_hi(idx_hi), .rdata_lo(p_lo), .rdata_hi(p_hi)
  );

  // pipeline control
  logic            s1_v, s2_v;
  logic [FW-1:0]   s1_frac;
  logic [PH_W-1:0] s1_ph;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_v      <= 1'b0;
      s2_v      <= 1'b0;
      out_valid <= 1'b0;
      s1_frac   <= '0;
      s1_ph     <= '0;
    end else begin
      s1_v      <= take;
      s2_v      <= s1_v;
      out_valid <= s2_v;
      if (take) begin
        s1_frac <= frac_msk;
        s1_ph   <= ph_in;
      end
    end
  end

  amdpd_interp #(.DW(AMP_W), .FW(FW), .SIGNED(1'b0)) u_amp_int (
    .clk(clk), .rst(rst), .ld_a(s1_v), .ld_b(s2_v),
    .lo(a_lo), .hi(a_hi), .frac(s1_frac), .offs('0), .y(amp_out)
  );

  amdpd_interp #(.DW(PH_W), .FW(FW), .SIGNED(1'b1)) u_ph_int (
    .clk(clk), .rst(rst), .ld_a(s1_v), .ld_b(s2_v),
    .lo(p_lo), .hi(p_hi), .frac(s1_frac), .offs(s1_ph), .y(ph_out)
  );
endmodule

// File: rtl/amdpd_chk.sv
module amdpd_chk #(
  parameter int AMP_W = 12,
  parameter int PH_W  = 12,
  parameter int RES_W = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             en,
  input logic             in_valid,
  input logic [RES_W-1:0] res_bits,
  input logic             out_valid,
  input logic [AMP_W-1:0] amp_out,
  input logic [PH_W-1:0]  ph_out,
  input logic [AMP_W-1:0] a_lo,
  input logic [AMP_W-1:0] a_hi
);
  logic [2:0] vp, zp;

  always_ff @(posedge clk) begin
    if (rst) begin
      vp <= '0;
      zp <= '0;
    end else begin
      vp <= {vp[1:0], in_valid & en};
      zp <= {zp[1:0], in_valid & en & (res_bits == '0)};
    end
  end

  // R2 / R3: result strobe three edges after an accepted sample
  assert_latency_R2: assert property (@(posedge clk) disable iff (rst)
    out_valid == vp[2]);

  // R9: outputs held when no result
  assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> ($stable(amp_out) && $stable(ph_out)));

  // R4: amplitude result lies between the two table neighbours
  assert_bounded_R4: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> ((amp_out >= (($past(a_lo, 2) < $past(a_hi, 2)) ? $past(a_lo, 2) : $past(a_hi, 2))) &&
                   (amp_out <= (($past(a_lo, 2) > $past(a_hi, 2)) ? $past(a_lo, 2) : $past(a_hi, 2)))));

  // R6: zero resolution returns the plain entry
  assert_zero_res_R6: assert property (@(posedge clk) disable iff (rst)
    (out_valid && zp[2]) |-> (amp_out == $past(a_lo, 2)));
endmodule

bind amdpd_core amdpd_chk #(.AMP_W(AMP_W), .PH_W(PH_W), .RES_W(RES_W)) u_chk (
  .clk(clk), .rst(rst), .en(en), .in_valid(in_valid), .res_bits(res_bits),
  .out_valid(out_valid), .amp_out(amp_out), .ph_out(ph_out),
  .a_lo(a_lo), .a_hi(a_hi)
);

// File: tb/amdpd_core_tb_top.sv
`timescale 1ns/1ps
module amdpd_core_tb_top;
  logic        clk = 0;
  logic        rst = 1;
  logic        en = 0, in_valid = 0, tbl_we = 0, tbl_sel = 0;
  logic [11:0] amp_in = 0, ph_in = 0, tbl_data = 0;
  logic [2:0]  res_bits = 0;
  logic [5:0]  tbl_addr = 0;
  logic        out_valid;
  logic [11:0] amp_out, ph_out;

  always #5 clk = ~clk;

  amdpd_core dut_i (
    .clk(clk), .rst(rst), .en(en), .in_valid(in_valid), .amp_in(amp_in),
    .ph_in(ph_in), .res_bits(res_bits), .tbl_we(tbl_we), .tbl_sel(tbl_sel),
    .tbl_addr(tbl_addr), .tbl_data(tbl_data), .out_valid(out_valid),
    .amp_out(amp_out), .ph_out(ph_out)
  );

  int n_cmp = 0, n_bad = 0;
  int mA [64];
  int mP [64];
  logic [23:0] q [$];
  string tq [$];
  bit done = 0;

  function automatic int lerp(int lo, int hi, int f);
    return lo + (((hi - lo) * f) >>> 6);
  endfunction

  function automatic int sx12(int v);
    return (v & 12'h800) ? (v & 12'hFFF) - 4096 : (v & 12'hFFF);
  endfunction

  task automatic check(string tag, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(bit sel, int a, int d);
    @(negedge clk);
    tbl_we = 1; tbl_sel = sel; tbl_addr = 6'(a); tbl_data = 12'(d);
    @(negedge clk);
    tbl_we = 0;
  endtask

  // driver: pushes the expected pair, then presents the sample
  task automatic send(int code, int ph, int r, string tag);
    int i, f, m, hi, ea, ep;
    i  = (code >> 6) & 63;
    m  = (r >= 6) ? 63 : ((63 << (6 - r)) & 63);
    f  = code & m;
    hi = (i == 63) ? 63 : i + 1;
    ea = lerp(mA[i], mA[hi], f) & 12'hFFF;
    ep = (ph + lerp(mP[i], mP[hi], f)) & 12'hFFF;
    q.push_back({12'(ea), 12'(ep)});
    tq.push_back(tag);
    @(negedge clk);
    in_valid = 1; amp_in = 12'(code); ph_in = 12'(ph); res_bits = 3'(r);
    @(negedge clk);
    in_valid = 0;
  endtask

  // monitor
  initial begin
    forever begin
      @(negedge clk);
      if (!rst && out_valid) begin
        if (q.size() == 0) begin
          check("R3 unexpected output", 1, 0);
        end else begin
          logic [23:0] e;
          string t;
          e = q.pop_front();
          t = tq.pop_front();
          check({t, " amp"}, amp_out, e[23:12]);
          check({t, " phase"}, ph_out, e[11:0]);
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 64; i++) begin
      mA[i] = i * 65 + ((i * i * 7) % 53);
      if (mA[i] > 4095) mA[i] = 4095;
      mP[i] = ((i * 37) % 301) - 150;
    end
    mA[40] = 1000;   // falling segment 39 -> 40 and rising 40 -> 41
    mP[63] = 120;    // positive correction at top for wrap tests
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 out_valid", out_valid, 0);
    check("R1 amp_out", amp_out, 0);
    check("R1 ph_out", ph_out, 0);
    rst = 0;
    @(negedge clk);
    check("R1 after release", out_valid, 0);

    // R8 load while disabled
    for (int i = 0; i < 64; i++) wr(1'b0, i, mA[i]);
    for (int i = 0; i < 64; i++) wr(1'b1, i, mP[i] & 12'hFFF);

    // R3 strobes with datapath disabled produce nothing
    @(negedge clk); in_valid = 1; amp_in = 12'd100;
    repeat (3) @(negedge clk);
    in_valid = 0;
    repeat (4) @(negedge clk);
    check("R3 no output while disabled", q.size(), 0);

    en = 1;
    // R8 write attempted while enabled is ignored (entries 10 and phase 10)
    wr(1'b0, 10, 0);
    wr(1'b1, 10, 12'h7FF);

    // R4 exact entries (fraction zero)
    send(10 << 6, 0, 6, "R8 ignored write entry 10");
    send(0, 0, 6, "R4 entry 0");
    send(25 << 6, 300, 6, "R4 entry 25");
    // R4 mid-segment rising and falling, R7 phase interpolation
    send((20 << 6) | 37, 1000, 6, "R4 R7 rising mid");
    send((39 << 6) | 45, 2000, 6, "R4 R7 falling mid");
    send((40 << 6) | 1, 50, 6, "R4 rising small frac");
    // R5 last entry
    send((63 << 6) | 63, 0, 6, "R5 top full frac");
    send((63 << 6) | 5, 7, 3, "R5 top reduced");
    // R7 wrap: positive correction past full scale
    send((63 << 6), 4090, 6, "R7 wrap up");
    send(2 << 6, 5, 6, "R7 wrap down");
    // R6 resolution settings on one code
    for (int r = 0; r < 8; r++) send((39 << 6) | 45, 100, r, "R6 resolution");
    // R2 back-to-back samples keep order and alignment
    @(negedge clk);
    for (int k = 0; k < 200; k++) begin
      int code, ph, r, i, m, f, hi;
      code = (k * 389 + 17) % 4096;
      ph   = (k * 977 + 3) % 4096;
      r    = k % 8;
      i  = (code >> 6) & 63;
      m  = (r >= 6) ? 63 : ((63 << (6 - r)) & 63);
      f  = code & m;
      hi = (i == 63) ? 63 : i + 1;
      q.push_back({12'(lerp(mA[i], mA[hi], f)), 12'((ph + lerp(mP[i], mP[hi], f)) & 12'hFFF)});
      tq.push_back("R2 R6 streaming sweep");
      in_valid = 1; amp_in = 12'(code); ph_in = 12'(ph); res_bits = 3'(r);
      @(negedge clk);
    end
    in_valid = 0;
    // R9 hold: last result stays while idle
    repeat (5) @(negedge clk);
    begin
      int ha, hp;
      ha = amp_out; hp = ph_out;
      repeat (4) @(negedge clk);
      check("R9 amp held", amp_out, ha);
      check("R9 phase held", ph_out, hp);
    end
    check("R2 all results drained", q.size(), 0);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule